// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves one branch instruction per valid strobe. It takes the 32-bit instruction word, the address of that instruction, the 32-bit condition register and the count and link registers. It decides whether the branch is taken and produces the next fetch address, along with the updated count and link values. All results are registered and appear one cycle after the strobe.

Three encodings are recognised. The first is a conditional branch with a 14-bit word displacement, which can be relative or absolute. The second is an unconditional branch with a 24-bit word displacement. The third is a conditional branch whose target is read from the link or count register. A conditional branch passes only if both of its gates pass. One gate is an optional count decrement followed by a zero test. The other is an optional test of one condition-register bit. Individual bits of a 5-bit option field turn each gate on or off.

A mode input selects 64-bit or 32-bit addressing. In 32-bit mode every produced address and every saved return address is cut to its low 32 bits. An instruction that is not a recognised branch passes through without effect.

Top module: `branch_resolve_unit`

## Requirements
- R1: Outputs update only on a clock edge where `valid_i` is high, one cycle later, and `out_valid_o` is high exactly in the cycle after a strobe. Without a strobe, `taken_o`, `next_pc_o`, `ctr_o` and `lr_o` hold their values.
- R2: Synchronous active-low reset clears `out_valid_o`, `taken_o`, `next_pc_o`, `ctr_o` and `lr_o` to zero.
- R3: For both conditional forms, when option bit 2 (instruction bit 23) is 0, `ctr_o` is `ctr_i - 1`, wrapping from zero to all ones. Otherwise, and for every other instruction, `ctr_o` equals `ctr_i`.
- R4: When option bit 2 is 0, the count gate passes only if "the decremented count is zero" equals option bit 1 (instruction bit 22). When option bit 2 is 1, the count gate always passes.
- R5: When option bit 4 (instruction bit 25) is 0, the condition gate passes only if `cr_i[31 - idx]` equals option bit 3 (instruction bit 24), where idx is instruction bits 20..16. When option bit 4 is 1, the condition gate always passes.
- R6: Opcode 16 (bits 31..26) is a conditional displacement branch. Its target is bits 15..2 followed by `00`, sign-extended, and added to `pc_i`. When bit 1 is 1, the target is that value alone (absolute).
- R7: Opcode 18 is always taken and leaves the count unchanged. Its target is bits 25..2 followed by `00`, sign-extended from bit 25, and is relative to `pc_i` unless bit 1 is 1.
- R8: Opcode 19 with bits 10..1 equal to 16 or 528 is a conditional register branch. Its target is `ctr_i` when bit 10 is 1 and `lr_i` otherwise, with the low two bits cleared. The target uses the values before this instruction's own count or link update.
- R9: For any recognised branch with bit 0 set, `lr_o` is `pc_i + 4`, whether or not the branch is taken. Otherwise `lr_o` equals `lr_i`.
- R10: A branch that is not taken gives `next_pc_o = pc_i + 4`.
- R11: With `mode64_i` = 0, `next_pc_o` and a link value written by bit 0 keep only their low 32 bits, and the upper bits are zero.
- R12: Any other instruction gives `taken_o` = 0, `next_pc_o = pc_i + 4`, and passes count and link through unchanged, even when bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Resolve the presented instruction |
| mode64_i | input | 1 | 1: 64-bit addresses, 0: 32-bit truncation |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| cr_i | input | 32 | Condition register |
| ctr_i | input | XLEN | Count register |
| lr_i | input | XLEN | Link register |
| out_valid_o | output | 1 | Results below are fresh |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | XLEN | Next fetch address |
| ctr_o | output | XLEN | Updated count register |
| lr_o | output | XLEN | Updated link register |

## Verification
The bench covers these corner cases:

- A decrement from zero that must wrap and still count as non-zero. A design that tested the count before decrementing would get this branch wrong.
- A count of one under each polarity of option bit 1. A swapped polarity would take a branch it should skip.
- Negative displacements, and the sign bit of the long form. Zero-extending them would jump forward instead of back.
- Register targets whose low bits are set. The target must be built from the count and link values before their own update. A design that used the decremented count or the fresh link value would jump to the wrong place.
- A 32-bit-mode address that carries past bit 31 and must wrap to a small value.
- A not-taken branch that still writes the link register.
- A non-branch word with the link bit set, which must leave every register untouched.

// File: rtl/bru_pkg.sv
// Shared constants and types for the branch resolution unit.
// Assumes a fixed 32-bit instruction word and a 32-bit condition register.
package bru_pkg;

    localparam int INSTR_W = 32;
    localparam int CR_W    = 32;

    localparam logic [5:0] OPC_COND_DISP = 6'd16;
    localparam logic [5:0] OPC_UNCOND    = 6'd18;
    localparam logic [5:0] OPC_REG_GROUP = 6'd19;
    localparam logic [9:0] XO_TO_LINK    = 10'd16;
    localparam logic [9:0] XO_TO_COUNT   = 10'd528;

    typedef enum logic [1:0] {
        BR_NONE      = 2'd0,
        BR_COND_DISP = 2'd1,
        BR_UNCOND    = 2'd2,
        BR_COND_REG  = 2'd3
    } br_kind_e;

endpackage

// File: rtl/bru_decode.sv
// Instruction field decoder: classifies the word and splits out the option
// field, condition-bit index, displacement bits and the two flag bits.
// Assumes nothing about validity; unknown words classify as BR_NONE.
module bru_decode
    import bru_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output br_kind_e           kind_o,
    output logic [4:0]         opt_o,
    output logic [4:0]         idx_o,
    output logic [23:0]        disp_o,
    output logic               abs_o,
    output logic               link_o,
    output logic               use_ctr_o
);

    logic [5:0] opc;
    logic [9:0] xo;

    // Field extraction and branch classification
    always_comb begin
        opc       = instr_i[31:26];
        xo        = instr_i[10:1];
        opt_o     = instr_i[25:21];
        idx_o     = instr_i[20:16];
        disp_o    = instr_i[25:2];
        abs_o     = instr_i[1];
        link_o    = instr_i[0];
        use_ctr_o = instr_i[10];
        kind_o    = BR_NONE;
        case (opc)
            OPC_COND_DISP: kind_o = BR_COND_DISP;
            OPC_UNCOND:    kind_o = BR_UNCOND;
            OPC_REG_GROUP: if (xo == XO_TO_LINK || xo == XO_TO_COUNT) kind_o = BR_COND_REG;
            default:       kind_o = BR_NONE;
        endcase
    end

endmodule

// File: rtl/bru_cond_eval.sv
// Taken decision: optional count decrement and zero test combined with an
// optional condition-register bit test. The bit index counts from the
// register's most significant bit. Assumes the kind comes from bru_decode.
module bru_cond_eval
    import bru_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  br_kind_e          kind_i,
    input  logic [4:0]        opt_i,
    input  logic [4:0]        idx_i,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [XLEN-1:0]   ctr_i,
    output logic              taken_o,
    output logic [XLEN-1:0]   ctr_next_o
);

    localparam logic [4:0] TOP_BIT = 5'(CR_W - 1);

    logic is_cond;
    logic dec_en;
    logic ctr_pass;
    logic cr_pass;
    logic cr_bit;

    // Count update followed by the two gates
    always_comb begin
        is_cond    = (kind_i == BR_COND_DISP) || (kind_i == BR_COND_REG);
        dec_en     = is_cond && !opt_i[2];
        ctr_next_o = dec_en ? (ctr_i - XLEN'(1)) : ctr_i;
        ctr_pass   = opt_i[2] || ((ctr_next_o == '0) == opt_i[1]);
        cr_bit     = cr_i[TOP_BIT - idx_i];
        cr_pass    = opt_i[4] || (cr_bit == opt_i[3]);
        case (kind_i)
            BR_NONE:   taken_o = 1'b0;
            BR_UNCOND: taken_o = 1'b1;
            default:   taken_o = ctr_pass && cr_pass;
        endcase
    end

endmodule

// File: rtl/bru_target_gen.sv
// Address generator: branch target, sequential address, chosen next address
// and the link value, each cut to 32 bits when 64-bit mode is off.
// Assumes XLEN is larger than 32 and register targets use pre-update values.
module bru_target_gen
    import bru_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  br_kind_e          kind_i,
    input  logic [23:0]       disp_i,
    input  logic              abs_i,
    input  logic              link_i,
    input  logic              use_ctr_i,
    input  logic              taken_i,
    input  logic              mode64_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   ctr_i,
    input  logic [XLEN-1:0]   lr_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic [XLEN-1:0]   lr_next_o,
    output logic [XLEN-1:0]   seq_pc_o
);

    localparam int HI_W = XLEN - 32;
    localparam int SX_S = XLEN - 16;
    localparam int SX_L = XLEN - 26;

    logic [XLEN-1:0] ofs_short;
    logic [XLEN-1:0] ofs_long;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] reg_tgt;
    logic [XLEN-1:0] raw_tgt;

    function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] a, input logic m64);
        return m64 ? a : {{HI_W{1'b0}}, a[31:0]};
    endfunction

    // Target selection and mode truncation
    always_comb begin
        ofs_short = {{SX_S{disp_i[13]}}, disp_i[13:0], 2'b00};
        ofs_long  = {{SX_L{disp_i[23]}}, disp_i, 2'b00};
        base      = abs_i ? '0 : pc_i;
        reg_tgt   = (use_ctr_i ? ctr_i : lr_i) & ~XLEN'(3);
        seq_pc_o  = fit(pc_i + XLEN'(4), mode64_i);
        case (kind_i)
            BR_COND_DISP: raw_tgt = base + ofs_short;
            BR_UNCOND:    raw_tgt = base + ofs_long;
            BR_COND_REG:  raw_tgt = reg_tgt;
            default:      raw_tgt = seq_pc_o;
        endcase
        next_pc_o = taken_i ? fit(raw_tgt, mode64_i) : seq_pc_o;
        lr_next_o = (kind_i != BR_NONE && link_i) ? seq_pc_o : lr_i;
    end

endmodule

// File: rtl/branch_resolve_unit.sv
// Top of the branch resolution unit: decodes, evaluates and registers the
// result one cycle after valid_i. Assumes a synchronous active-low reset.
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic               mode64_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [CR_W-1:0]    cr_i,
    input  logic [XLEN-1:0]    ctr_i,
    input  logic [XLEN-1:0]    lr_i,
    output logic               out_valid_o,
    output logic               taken_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic [XLEN-1:0]    ctr_o,
    output logic [XLEN-1:0]    lr_o
);

    br_kind_e        kind_c;
    logic [4:0]      opt_c;
    logic [4:0]      idx_c;
    logic [23:0]     disp_c;
    logic            abs_c;
    logic            link_c;
    logic            use_ctr_c;
    logic            taken_c;
    logic [XLEN-1:0] ctr_c;
    logic [XLEN-1:0] next_c;
    logic [XLEN-1:0] lr_c;
    logic [XLEN-1:0] seq_c;

    bru_decode u_decode (
        .instr_i   (instr_i),
        .kind_o    (kind_c),
        .opt_o     (opt_c),
        .idx_o     (idx_c),
        .disp_o    (disp_c),
        .abs_o     (abs_c),
        .link_o    (link_c),
        .use_ctr_o (use_ctr_c)
    );

    bru_cond_eval #(.XLEN(XLEN)) u_cond (
        .kind_i     (kind_c),
        .opt_i      (opt_c),
        .idx_i      (idx_c),
        .cr_i       (cr_i),
        .ctr_i      (ctr_i),
        .taken_o    (taken_c),
        .ctr_next_o (ctr_c)
    );

    bru_target_gen #(.XLEN(XLEN)) u_target (
        .kind_i    (kind_c),
        .disp_i    (disp_c),
        .abs_i     (abs_c),
        .link_i    (link_c),
        .use_ctr_i (use_ctr_c),
        .taken_i   (taken_c),
        .mode64_i  (mode64_i),
        .pc_i      (pc_i),
        .ctr_i     (ctr_i),
        .lr_i      (lr_i),
        .next_pc_o (next_c),
        .lr_next_o (lr_c),
        .seq_pc_o  (seq_c)
    );

    // Result registers, loaded only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            taken_o     <= 1'b0;
            next_pc_o   <= '0;
            ctr_o       <= '0;
            lr_o        <= '0;
        end else begin
            out_valid_o <= valid_i;
            if (valid_i) begin
                taken_o   <= taken_c;
                next_pc_o <= next_c;
                ctr_o     <= ctr_c;
                lr_o      <= lr_c;
            end
        end
    end

    logic is_cond_a;
    logic cr_sel_a;
    assign is_cond_a = (kind_c == BR_COND_DISP) || (kind_c == BR_COND_REG);
    assign cr_sel_a  = cr_i[5'd31 - instr_i[20:16]];

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> out_valid_o);

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(next_pc_o) && $stable(ctr_o) && $stable(lr_o) && $stable(taken_o)));

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_cond_a && !instr_i[23]) |=> (ctr_o == $past(ctr_i) - XLEN'(1)));

    a_r5_cr_block: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_cond_a && !instr_i[25] && (cr_sel_a != instr_i[24])) |=> !taken_o);

    a_r7_uncond: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_c == BR_UNCOND) |=> (taken_o && ctr_o == $past(ctr_i)));

    a_r10_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !taken_c) |=> (next_pc_o == $past(seq_c)));

    a_r11_trunc: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mode64_i) |=> (next_pc_o[XLEN-1:32] == '0));

endmodule

// File: tb/branch_resolve_unit_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// checks for reset and output hold.
module branch_resolve_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int NVEC = 24;

    typedef struct packed {
        logic [31:0]     instr;
        logic [XLEN-1:0] pc;
        logic [31:0]     cr;
        logic [XLEN-1:0] ctr;
        logic [XLEN-1:0] lr;
        logic            m64;
        logic            tk;
        logic [XLEN-1:0] nx;
        logic [XLEN-1:0] ectr;
        logic [XLEN-1:0] elr;
    } vec_t;

    function automatic logic [31:0] mk_bc(input logic [4:0] bo, input logic [4:0] bi,
                                          input logic [15:0] off, input logic aa, input logic lk);
        return {6'd16, bo, bi, off[15:2], aa, lk};
    endfunction

    function automatic logic [31:0] mk_b(input logic [25:0] off, input logic aa, input logic lk);
        return {6'd18, off[25:2], aa, lk};
    endfunction

    function automatic logic [31:0] mk_rg(input logic [4:0] bo, input logic [4:0] bi,
                                          input logic to_ctr, input logic lk);
        return {6'd19, bo, bi, 5'd0, (to_ctr ? 10'd528 : 10'd16), lk};
    endfunction

    localparam vec_t VEC [NVEC] = '{
        // 0..2: R6 relative, negative and absolute displacement
        '{mk_bc(5'b10100, 5'd0, 16'h0040, 1'b0, 1'b0), 64'h1000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h1040, 64'h10, 64'hAA0},
        '{mk_bc(5'b10100, 5'd0, 16'hFFF0, 1'b0, 1'b0), 64'h1000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h0FF0, 64'h10, 64'hAA0},
        '{mk_bc(5'b10100, 5'd0, 16'h0200, 1'b1, 1'b0), 64'h1000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h0200, 64'h10, 64'hAA0},
        // 3..4: R5 condition bit match and mismatch (R10 fall-through)
        '{mk_bc(5'b01100, 5'd2, 16'h0008, 1'b0, 1'b0), 64'h2000, 32'h2000_0000, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h2008, 64'h10, 64'hAA0},
        '{mk_bc(5'b01100, 5'd2, 16'h0008, 1'b0, 1'b0), 64'h2000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b0, 64'h2004, 64'h10, 64'hAA0},
        // 5..8: R3/R4 decrement, zero test polarity, wrap from zero
        '{mk_bc(5'b10000, 5'd0, 16'h0020, 1'b0, 1'b0), 64'h3000, 32'h0, 64'h5, 64'hAA0, 1'b1, 1'b1, 64'h3020, 64'h4, 64'hAA0},
        '{mk_bc(5'b10000, 5'd0, 16'h0020, 1'b0, 1'b0), 64'h3000, 32'h0, 64'h1, 64'hAA0, 1'b1, 1'b0, 64'h3004, 64'h0, 64'hAA0},
        '{mk_bc(5'b10010, 5'd0, 16'h0020, 1'b0, 1'b0), 64'h3000, 32'h0, 64'h1, 64'hAA0, 1'b1, 1'b1, 64'h3020, 64'h0, 64'hAA0},
        '{mk_bc(5'b10000, 5'd0, 16'h0020, 1'b0, 1'b0), 64'h3000, 32'h0, 64'h0, 64'hAA0, 1'b1, 1'b1, 64'h3020, {XLEN{1'b1}}, 64'hAA0},
        // 9..10: R9 link on taken and on not taken
        '{mk_bc(5'b10100, 5'd0, 16'h0100, 1'b0, 1'b1), 64'h4000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h4100, 64'h10, 64'h4004},
        '{mk_bc(5'b01100, 5'd0, 16'h0100, 1'b0, 1'b1), 64'h4000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b0, 64'h4004, 64'h10, 64'h4004},
        // 11..12: R7 unconditional, negative relative and absolute with link
        '{mk_b(26'h3FF_FF00, 1'b0, 1'b0), 64'h5000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h4F00, 64'h10, 64'hAA0},
        '{mk_b(26'h001_2340, 1'b1, 1'b1), 64'h5000, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h12340, 64'h10, 64'h5004},
        // 13..15: R8 register targets, low bits cleared, old values used
        '{mk_rg(5'b10100, 5'd0, 1'b0, 1'b0), 64'h6000, 32'h0, 64'h8888, 64'h7777_0003, 1'b1, 1'b1, 64'h7777_0000, 64'h8888, 64'h7777_0003},
        '{mk_rg(5'b10100, 5'd0, 1'b1, 1'b1), 64'h6000, 32'h0, 64'h8888_0002, 64'h1234, 1'b1, 1'b1, 64'h8888_0000, 64'h8888_0002, 64'h6004},
        '{mk_rg(5'b10100, 5'd0, 1'b0, 1'b1), 64'h6000, 32'h0, 64'h10, 64'h9000, 1'b1, 1'b1, 64'h9000, 64'h10, 64'h6004},
        // 16..18: R11 truncation vs 64-bit mode
        '{mk_bc(5'b10100, 5'd0, 16'h0020, 1'b0, 1'b1), 64'hFFFF_FFF0, 32'h0, 64'h10, 64'hAA0, 1'b0, 1'b1, 64'h10, 64'h10, 64'hFFFF_FFF4},
        '{mk_bc(5'b10100, 5'd0, 16'h0020, 1'b0, 1'b1), 64'hFFFF_FFF0, 32'h0, 64'h10, 64'hAA0, 1'b1, 1'b1, 64'h1_0000_0010, 64'h10, 64'hFFFF_FFF4},
        '{mk_bc(5'b01100, 5'd0, 16'h0020, 1'b0, 1'b1), 64'hABCD_0000_FFFF_FFFC, 32'h0, 64'h10, 64'hAA0, 1'b0, 1'b0, 64'h0, 64'h10, 64'h0},
        // 19..20: R12 non-branch words, link bit ignored
        '{32'h7C00_0001, 64'h8000, 32'h0, 64'h55, 64'h66, 1'b1, 1'b0, 64'h8004, 64'h55, 64'h66},
        '{32'h4C00_012D, 64'h8000, 32'h0, 64'h55, 64'h66, 1'b1, 1'b0, 64'h8004, 64'h55, 64'h66},
        // 21: R3 R4 R5 both gates active
        '{mk_bc(5'b00000, 5'd3, 16'h0010, 1'b0, 1'b0), 64'h9000, 32'h0, 64'h2, 64'hAA0, 1'b1, 1'b1, 64'h9010, 64'h1, 64'hAA0},
        // 22: R8 count target is the value before decrement
        '{mk_rg(5'b10000, 5'd0, 1'b1, 1'b0), 64'h6000, 32'h0, 64'h100, 64'hAA0, 1'b1, 1'b1, 64'h100, 64'hFF, 64'hAA0},
        // 23: R8 R11 count target truncated in 32-bit mode
        '{mk_rg(5'b10100, 5'd0, 1'b1, 1'b0), 64'h6000, 32'h0, 64'h1_2345_6787, 64'hAA0, 1'b0, 1'b1, 64'h2345_6784, 64'h1_2345_6787, 64'hAA0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid_i = 1'b0;
    logic            mode64_i = 1'b1;
    logic [31:0]     instr_i = '0;
    logic [XLEN-1:0] pc_i = '0;
    logic [31:0]     cr_i = '0;
    logic [XLEN-1:0] ctr_i = '0;
    logic [XLEN-1:0] lr_i = '0;
    logic            out_valid_o;
    logic            taken_o;
    logic [XLEN-1:0] next_pc_o;
    logic [XLEN-1:0] ctr_o;
    logic [XLEN-1:0] lr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_resolve_unit #(.XLEN(XLEN)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .mode64_i    (mode64_i),
        .instr_i     (instr_i),
        .pc_i        (pc_i),
        .cr_i        (cr_i),
        .ctr_i       (ctr_i),
        .lr_i        (lr_i),
        .out_valid_o (out_valid_o),
        .taken_o     (taken_o),
        .next_pc_o   (next_pc_o),
        .ctr_o       (ctr_o),
        .lr_o        (lr_o)
    );

    task automatic chk(input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 reset out_valid", XLEN'(out_valid_o), '0);
        chk("R2 reset taken", XLEN'(taken_o), '0);
        chk("R2 reset next_pc", next_pc_o, '0);
        chk("R2 reset ctr", ctr_o, '0);
        chk("R2 reset lr", lr_o, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            instr_i  = VEC[i].instr;
            pc_i     = VEC[i].pc;
            cr_i     = VEC[i].cr;
            ctr_i    = VEC[i].ctr;
            lr_i     = VEC[i].lr;
            mode64_i = VEC[i].m64;
            valid_i  = 1'b1;
            @(negedge clk);
            chk($sformatf("R1 vec %0d out_valid", i), XLEN'(out_valid_o), XLEN'(1));
            chk($sformatf("vec %0d taken (R4 R5 R7 R12)", i), XLEN'(taken_o), XLEN'(VEC[i].tk));
            chk($sformatf("vec %0d next_pc (R6 R7 R8 R10 R11)", i), next_pc_o, VEC[i].nx);
            chk($sformatf("vec %0d ctr (R3)", i), ctr_o, VEC[i].ectr);
            chk($sformatf("vec %0d lr (R9)", i), lr_o, VEC[i].elr);
        end

        // R1: no strobe, inputs change, outputs hold
        valid_i  = 1'b0;
        instr_i  = mk_b(26'h000_0100, 1'b0, 1'b1);
        pc_i     = 64'hDEAD_0000;
        ctr_i    = 64'h7;
        lr_i     = 64'h9;
        mode64_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 hold out_valid low", XLEN'(out_valid_o), '0);
        chk("R1 hold next_pc", next_pc_o, VEC[NVEC-1].nx);
        chk("R1 hold ctr", ctr_o, VEC[NVEC-1].ectr);
        chk("R1 hold lr", lr_o, VEC[NVEC-1].elr);
        chk("R1 hold taken", XLEN'(taken_o), XLEN'(1));

        // R7 R9: one strobe on the new inputs
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R7 directed next_pc", next_pc_o, 64'hDEAD_0100);
        chk("R9 directed lr", lr_o, 64'hDEAD_0004);

        // R2: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 mid-run next_pc", next_pc_o, '0);
        chk("R2 mid-run ctr", ctr_o, '0);
        chk("R2 mid-run lr", lr_o, '0);
        chk("R2 mid-run taken", XLEN'(taken_o), '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule